// File: doc/BRIEF.md
# Variable-Length Serial Shift Data Register

This block is the data path of one serial channel. The host sees one 16-bit register. The top seven bits choose how fast bits move on the wire. The low bits hold the word that is sent or the word that was received. A private 9-bit shift register sits behind that buffer. On a transmit start it loads the buffer and drives the bits onto `ser_out`, one bit per baud tick. On a receive start it samples `ser_in` once per baud tick and, at the end, writes the result back into the buffer.

The word length is 7, 8 or 9 bits. The first bit on the wire can be the MSB or the LSB. Whatever the bit order, the buffer always holds the word right-aligned. A channel built without the ninth-bit option has an 8-bit buffer. On such a channel a 9-bit length selection behaves as 8 bits. Start, parity and stop framing, and all protocol sequencing, belong to the logic around this block.

Top module: `ser_data_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register clears to 0x0000, `busy` goes to 0, `rx_done` goes to 0 and `ser_out` idles at 1.
- R2: When `wr16_en` is high at a clock edge, all 16 register bits take `wr_data`. Bits 15:9 form the clock-division field and are read back unchanged on `rd_data`.
- R3: When `wr8_en` is high and `chan_en` is 1, only bits 7:0 take `wr_data[7:0]`. When `chan_en` is 0, a byte write leaves the register unchanged.
- R4: `len_sel` selects the word length: 2'b00 gives 7 bits (bits 6:0), 2'b01 gives 8 bits (bits 7:0), 2'b10 gives 9 bits (bits 8:0), and 2'b11 gives 8 bits.
- R5: With parameter `NINE_OK` = 0, bit 8 of the register always reads 0 and a 2'b10 selection transfers 8 bits.
- R6: Each bit lasts exactly (D+1)*2 clock cycles on the wire, where D is the value in bits 15:9.
- R7: On a transmit start, `ser_out` shows the first bit in the cycle after the start edge. The word is sent LSB first when `msb_first` is 0 and MSB first when it is 1. After the last bit, `ser_out` returns to 1 and `busy` falls.
- R8: On a receive, `ser_in` is sampled at the end of each bit period. When the last bit is sampled, two things happen in the same cycle: bits 8:0 receive the word, right-aligned and zero above the selected length, and `rx_done` is high for exactly one cycle. Bits 15:9 are left unchanged.
- R9: A start is ignored while `chan_en` is 0 or while a transfer is in progress. If `tx_start` and `rx_start` are raised together, the transmit is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel enable; gates byte writes and starts |
| wr16_en | input | 1 | Full-width register write strobe |
| wr8_en | input | 1 | Low-byte register write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Register contents |
| len_sel | input | 2 | Word-length select |
| msb_first | input | 1 | 1: MSB first on the wire; 0: LSB first |
| tx_start | input | 1 | Start a transmit from the buffer |
| rx_start | input | 1 | Start a receive into the buffer |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output, idles at 1 |
| busy | output | 1 | A transfer is in progress |
| rx_done | output | 1 | One-cycle pulse when a received word lands |

## Verification
The bench preloads the buffer with all ones before each receive. A design that fails to zero-fill above a 7- or 8-bit word is therefore caught by the leftover ones. Every length is run in both bit orders, so a design that packs MSB-first words at bit 8 instead of right-aligning them produces a shifted word. Each bit is sampled at the first and the last cycle of its period, which exposes a divider that is off by one cycle. Further tests cover a byte write while the channel is stopped, extra starts raised in the middle of a transfer, and a second instance built without the ninth bit. A design that writes anyway, restarts, or keeps bit 8 fails these tests.

// File: rtl/ser_data_pkg.sv
// Package: shared length encoding and helpers for the serial data register.
// Assumes the shift path is never wider than 9 bits.
package ser_data_pkg;

    localparam int unsigned SHIFT_W = 9;

    typedef enum logic [1:0] {
        LEN_7   = 2'b00,
        LEN_8   = 2'b01,
        LEN_9   = 2'b10,
        LEN_ALT = 2'b11
    } len_sel_e;

    // Turn a length select into a bit count, with 9 folded to 8 when not built.
    function automatic logic [3:0] eff_len(input logic [1:0] sel, input logic nine_ok);
        case (sel)
            LEN_7:   return 4'd7;
            LEN_9:   return nine_ok ? 4'd9 : 4'd8;
            default: return 4'd8;
        endcase
    endfunction

    // Mask of the low n bits of the shift path.
    function automatic logic [SHIFT_W-1:0] len_mask(input logic [3:0] n);
        logic [SHIFT_W:0] t;
        t = ({{SHIFT_W{1'b0}}, 1'b1} << n) - 1'b1;
        return t[SHIFT_W-1:0];
    endfunction

endpackage

// File: rtl/sdr_baud_gen.sv
// Module: baud tick generator.
// Emits a one-cycle tick every (div+1)*2 operation-clock cycles while run is high.
// The count restarts from zero whenever run drops.
module sdr_baud_gen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = {div, 1'b1};
    assign tick  = run && (cnt_q == limit);

    // Count operation-clock cycles within one bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R6: a bit period lasts at least two cycles.
    assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R6: a tick only ends a period that was running.
    assert_tick_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(run));

endmodule

// File: rtl/sdr_shifter.sv
// Module: 9-bit shift engine with no host access.
// Transmit loads a masked word and shifts it out. Receive shifts ser_in in.
// Length and order are latched at start. The next shift value is arranged so
// that, after n shifts, the received word is right-aligned and zero above n.
module sdr_shifter
    import ser_data_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_tx,
    input  logic               go_rx,
    input  logic               tick,
    input  logic [3:0]         len_in,
    input  logic               msb_in,
    input  logic [SHIFT_W-1:0] tx_word,
    input  logic               ser_in,
    output logic               ser_out,
    output logic               busy,
    output logic               cap,
    output logic [SHIFT_W-1:0] cap_word,
    output logic [3:0]         len_cur
);
    logic               busy_q, rx_q, msbf_q;
    logic [3:0]         left_q, len_q;
    logic [SHIFT_W-1:0] sh_q, nxt, mask, topbit;
    logic               ins;

    // Next shift value; the inserted bit enters at bit 0 (MSB first) or at the top of the length (LSB first).
    always_comb begin
        mask   = len_mask(len_q);
        topbit = mask & ~(mask >> 1);
        ins    = rx_q & ser_in;
        if (msbf_q)
            nxt = ((sh_q << 1) | {{(SHIFT_W-1){1'b0}}, ins}) & mask;
        else
            nxt = (sh_q >> 1) | (ins ? topbit : '0);
    end

    assign cap      = busy_q && rx_q && tick && (left_q == 4'd1);
    assign cap_word = nxt;
    assign busy     = busy_q;
    assign len_cur  = len_q;
    assign ser_out  = (busy_q && !rx_q) ? (msbf_q ? |(sh_q & topbit) : sh_q[0]) : 1'b1;

    // Start, shift on each tick, and stop after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            rx_q   <= 1'b0;
            msbf_q <= 1'b0;
            left_q <= '0;
            len_q  <= '0;
            sh_q   <= '0;
        end else if (!busy_q && (go_tx || go_rx)) begin
            busy_q <= 1'b1;
            rx_q   <= !go_tx;
            msbf_q <= msb_in;
            len_q  <= len_in;
            left_q <= len_in;
            sh_q   <= go_tx ? (tx_word & len_mask(len_in)) : '0;
        end else if (busy_q && tick) begin
            sh_q   <= nxt;
            left_q <= left_q - 4'd1;
            if (left_q == 4'd1)
                busy_q <= 1'b0;
        end
    end

    // R8: the capture strobe ends the transfer.
    assert_cap_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> !busy);
    // R4: bits remaining stay within the latched length.
    assert_left_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (left_q != 4'd0) && (left_q <= len_q));
    // R9: a transfer in flight keeps its direction, length and order.
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rx_q) && $stable(len_q) && $stable(msbf_q));

endmodule

// File: rtl/sdr_buf_reg.sv
// Module: the 16-bit register that holds the division field and the data buffer.
// A received word overrides any write to the low bits in the same cycle.
// Without the ninth-bit option, bit 8 is held at 0.
module sdr_buf_reg
    import ser_data_pkg::*;
#(
    parameter bit NINE_OK = 1'b1,
    parameter int DIV_W   = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chan_en,
    input  logic                     wr16,
    input  logic                     wr8,
    input  logic [DIV_W+SHIFT_W-1:0] wdata,
    input  logic                     cap,
    input  logic [SHIFT_W-1:0]       cap_word,
    output logic [DIV_W+SHIFT_W-1:0] q
);
    localparam int REG_W = DIV_W + SHIFT_W;
    localparam logic [SHIFT_W-1:0] KEEP = NINE_OK ? {SHIFT_W{1'b1}} : {1'b0, {(SHIFT_W-1){1'b1}}};

    // Apply host writes, then let a received word take the buffer bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (wr16)
                q <= wdata & {{DIV_W{1'b1}}, KEEP};
            else if (wr8 && chan_en)
                q[7:0] <= wdata[7:0];
            if (cap)
                q[SHIFT_W-1:0] <= cap_word & KEEP;
        end
    end

    // R3: a byte write while the channel is stopped changes nothing.
    assert_byte_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr8 && !chan_en && !wr16 && !cap) |=> $stable(q));

    generate
        if (!NINE_OK) begin : g_no_ninth
            // R5: bit 8 never holds a 1 on an 8-bit channel.
            assert_no_ninth_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
                q[SHIFT_W-1] == 1'b0);
        end
    endgenerate

    logic unused_hi;
    assign unused_hi = ^q[REG_W-1:SHIFT_W];

endmodule

// File: rtl/ser_data_reg.sv
// Module: top of the serial data register.
// Ties the register, baud generator and shift engine together.
// Starts are gated by chan_en; transmit wins over receive.
module ser_data_reg
    import ser_data_pkg::*;
#(
    parameter bit NINE_OK = 1'b1,
    parameter int DIV_W   = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chan_en,
    input  logic                     wr16_en,
    input  logic                     wr8_en,
    input  logic [DIV_W+SHIFT_W-1:0] wr_data,
    output logic [DIV_W+SHIFT_W-1:0] rd_data,
    input  logic [1:0]               len_sel,
    input  logic                     msb_first,
    input  logic                     tx_start,
    input  logic                     rx_start,
    input  logic                     ser_in,
    output logic                     ser_out,
    output logic                     busy,
    output logic                     rx_done
);
    localparam int REG_W = DIV_W + SHIFT_W;

    logic               go_tx, go_rx, tick, cap;
    logic [SHIFT_W-1:0] cap_word;
    logic [3:0]         len_cur;
    logic [REG_W-1:0]   q;

    assign go_tx   = chan_en && tx_start;
    assign go_rx   = chan_en && rx_start && !tx_start;
    assign rd_data = q;

    sdr_buf_reg #(.NINE_OK(NINE_OK), .DIV_W(DIV_W)) buf_i (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr16(wr16_en), .wr8(wr8_en),
        .wdata(wr_data), .cap(cap), .cap_word(cap_word), .q(q)
    );

    sdr_baud_gen #(.DIV_W(DIV_W)) baud_i (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(q[REG_W-1:SHIFT_W]), .tick(tick)
    );

    sdr_shifter shift_i (
        .clk(clk), .rst_n(rst_n), .go_tx(go_tx), .go_rx(go_rx), .tick(tick),
        .len_in(eff_len(len_sel, NINE_OK)), .msb_in(msb_first),
        .tx_word(q[SHIFT_W-1:0]), .ser_in(ser_in), .ser_out(ser_out), .busy(busy),
        .cap(cap), .cap_word(cap_word), .len_cur(len_cur)
    );

    // Delay the capture strobe so it marks the cycle the word is visible.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_done <= 1'b0;
        else
            rx_done <= cap;
    end

    // R8: a fresh word has nothing above its length.
    assert_zero_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> ((rd_data[SHIFT_W-1:0] & ~len_mask(len_cur)) == '0));
    // R8: the done strobe lasts one cycle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

endmodule

// File: tb/ser_data_reg_tb.sv
// Directed bench for ser_data_reg. One task per scenario; every task checks its own results.
// Inputs are driven and outputs sampled on the falling edge.
module ser_data_reg_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, chan_en, wr16_en, wr8_en, msb_first, tx_start, rx_start, ser_in;
    logic [15:0] wr_data, rd_data, rd8;
    logic [1:0]  len_sel;
    logic        ser_out, busy, rx_done, ser_out8, busy8, rx_done8;
    int          vectors = 0;
    int          miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_data_reg dut_i (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr16_en(wr16_en), .wr8_en(wr8_en),
        .wr_data(wr_data), .rd_data(rd_data), .len_sel(len_sel), .msb_first(msb_first),
        .tx_start(tx_start), .rx_start(rx_start), .ser_in(ser_in), .ser_out(ser_out),
        .busy(busy), .rx_done(rx_done)
    );

    ser_data_reg #(.NINE_OK(1'b0)) dut8_i (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr16_en(wr16_en), .wr8_en(wr8_en),
        .wr_data(wr_data), .rd_data(rd8), .len_sel(len_sel), .msb_first(msb_first),
        .tx_start(tx_start), .rx_start(rx_start), .ser_in(ser_in), .ser_out(ser_out8),
        .busy(busy8), .rx_done(rx_done8)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write16(input logic [15:0] d);
        @(negedge clk); wr16_en = 1'b1; wr_data = d;
        @(negedge clk); wr16_en = 1'b0;
    endtask

    function automatic int len_of(input logic [1:0] sel);
        return (sel == 2'b00) ? 7 : (sel == 2'b10) ? 9 : 8;
    endfunction

    // R1: state right after reset.
    task automatic t_reset();
        check("R1 rd_data", rd_data, 16'h0000);
        check("R1 ser_out/busy/rx_done", {13'd0, ser_out, busy, rx_done}, 16'h0004);
    endtask

    // R2: full write and division field readback.
    task automatic t_write16();
        write16(16'hA5C3);
        check("R2 full write", rd_data, 16'hA5C3);
        check("R2 div field", {9'd0, rd_data[15:9]}, 16'h0052);
    endtask

    // R3: byte write locked while stopped, accepted while enabled.
    task automatic t_byte_lock();
        write16(16'h0123);
        chan_en = 1'b0;
        @(negedge clk); wr8_en = 1'b1; wr_data = 16'hFFFF;
        @(negedge clk); wr8_en = 1'b0;
        check("R3 byte write while stopped", rd_data, 16'h0123);
        chan_en = 1'b1;
        @(negedge clk); wr8_en = 1'b1; wr_data = 16'hEE5A;
        @(negedge clk); wr8_en = 1'b0;
        check("R3 byte write while enabled", rd_data, 16'h015A);
    endtask

    // R4 R6 R7 (and R9 when poke is set): transmit one word and check each bit at both ends of its period.
    task automatic t_tx(input logic [1:0] sel, input bit msb, input int div,
                        input logic [8:0] data, input bit poke);
        int n = len_of(sel);
        int p = (div + 1) * 2;
        logic [8:0] exp_w = '0, got_a = '0, got_b = '0;
        write16({7'(div), data});
        len_sel = sel; msb_first = msb;
        @(negedge clk); tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            exp_w[k] = msb ? data[n-1-k] : data[k];
            got_a[k] = ser_out;
            if (k == 0) check("R7 busy during transmit", {15'd0, busy}, 16'd1);
            if (k == 1 && poke) begin tx_start = 1'b1; rx_start = 1'b1; end
            repeat (p - 1) @(negedge clk);
            got_b[k] = ser_out;
            tx_start = 1'b0; rx_start = 1'b0;
            @(negedge clk);
        end
        check(poke ? "R9 R7 bits with extra starts" : "R4 R7 bits at period start", {7'd0, got_a}, {7'd0, exp_w});
        check("R6 bits at period end", {7'd0, got_b}, {7'd0, exp_w});
        check("R7 idle after last bit", {14'd0, ser_out, busy}, 16'h0002);
    endtask

    // R4 R8: receive one word over a buffer preloaded with ones.
    task automatic t_rx(input logic [1:0] sel, input bit msb, input int div, input logic [8:0] bits);
        int n = len_of(sel);
        int p = (div + 1) * 2;
        logic [8:0] exp_w = '0;
        write16({7'(div), 9'h1FF});
        len_sel = sel; msb_first = msb;
        @(negedge clk); rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            ser_in = bits[k];
            if (msb) exp_w[n-1-k] = bits[k]; else exp_w[k] = bits[k];
            if (k == n - 1) begin
                repeat (p - 1) @(negedge clk);
                check("R8 no early done", {15'd0, rx_done}, 16'd0);
                @(negedge clk);
            end else begin
                repeat (p) @(negedge clk);
            end
        end
        check("R8 done pulse", {15'd0, rx_done}, 16'd1);
        check("R4 R8 received word", rd_data, {7'(div), exp_w});
        @(negedge clk);
        check("R8 done one cycle", {15'd0, rx_done}, 16'd0);
        ser_in = 1'b1;
    endtask

    // R9: start with the channel stopped is ignored.
    task automatic t_disabled_start();
        chan_en = 1'b0;
        @(negedge clk); tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        check("R9 no start while stopped", {14'd0, busy, ser_out}, 16'h0001);
        chan_en = 1'b1;
    endtask

    // R5: channel built without the ninth bit.
    task automatic t_nine_off();
        logic [7:0] b = 8'hB4;
        write16(16'h01FF);
        check("R5 bit 8 dropped", rd8, 16'h00FF);
        check("R5 bit 8 kept when built", rd_data, 16'h01FF);
        len_sel = 2'b10; msb_first = 1'b0;
        @(negedge clk); rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            ser_in = b[k];
            repeat (2) @(negedge clk);
        end
        check("R5 nine-select done after 8 bits", {15'd0, rx_done8}, 16'd1);
        check("R5 nine-select word", rd8, {8'd0, b});
        ser_in = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; chan_en = 1'b1; wr16_en = 1'b0; wr8_en = 1'b0; wr_data = '0;
        len_sel = 2'b01; msb_first = 1'b0; tx_start = 1'b0; rx_start = 1'b0; ser_in = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write16();
        t_byte_lock();
        t_tx(2'b01, 1'b0, 0, 9'h0B2, 1'b0);
        t_tx(2'b00, 1'b1, 2, 9'h1C6, 1'b0);
        t_tx(2'b10, 1'b0, 1, 9'h12D, 1'b0);
        t_tx(2'b10, 1'b1, 0, 9'h1A3, 1'b1);
        t_tx(2'b11, 1'b1, 3, 9'h05B, 1'b0);
        t_rx(2'b00, 1'b0, 0, 9'h055);
        t_rx(2'b00, 1'b1, 1, 9'h033);
        t_rx(2'b01, 1'b1, 0, 9'h0C9);
        t_rx(2'b10, 1'b1, 2, 9'h16B);
        t_rx(2'b10, 1'b0, 0, 9'h0D2);
        t_disabled_start();
        t_nine_off();
        finish_run();
    end
endmodule